// File: doc/BRIEF.md
# Dual-Clock Timer with Staged Register Transfer

This block is an 8-bit up-counter with two compare channels. The counter runs either from the system clock or from a separate, slower oscillator clock, and a source-select input picks between the two. The configuration bus always runs on the system clock. A written value first lands in a system-side staging register and then crosses into the timer clock domain through a toggle handshake. For each of the five writable registers, a busy bit stays set until that handshake has completed.

Timer events come back to the system side the same way, as toggles. Three events are reported: counter wrap, compare match on channel A and compare match on channel B. On the system side each toggle becomes a one-cycle set pulse into a flag register, and software clears the flags by writing ones. Channel A can also clear the counter on a match. Each channel drives an output pin that a match can leave alone, toggle, clear or set.

The bus has a single write port and a combinational read port. Software writes a register, polls the busy bits until its bit reads zero, and only then writes that register again.

Top module: `async_timer_bridge`

## Requirements
- R1: After reset the counter is 0, both pins are 0, all busy bits and flags are 0, the staged registers read 0, and the clock-select code is 0, so the timer is stopped.
- R2: When src_sel is 0 the timer domain is clocked by clk. When src_sel is 1 it is clocked by osc_clk, which must run at no more than a quarter of the clk rate. src_sel may change only while the timer is stopped.
- R3: A write to address 0 (counter), 1 (compare A), 2 (compare B), 3 (control A) or 4 (control B) whose busy bit is clear does three things: it stores the data in the staging register, which then reads back at the same address, and it sets the busy bit. The busy bits read at address 5, bit k belonging to address k. With src_sel 0, a write sampled at edge W takes effect in the timer at edge W+3, and its busy bit reads 0 again from edge W+5.
- R4: A write to an address 0 to 4 whose busy bit is set is ignored. The staged value and the value finally transferred are those of the earlier write.
- R5: Control B bits [2:0] set the tick rate of the counter in timer clocks: code 0 stops it, and codes 1 to 7 divide by 1, 8, 32, 64, 128, 256 and 1024.
- R6: On each tick the counter adds one and wraps from 255 to 0. A tick at count 255 raises the wrap event.
- R7: When control A bit 4 is set, a tick at a count equal to compare A returns the counter to 0, so the match period is compare A plus 1 ticks.
- R8: A tick at a count equal to compare A acts on pin_a according to control A bits [1:0]; a match on compare B acts on pin_b according to bits [3:2]. The codes are 00 none, 01 toggle, 10 clear and 11 set.
- R9: The flags read at address 6: bit 0 wrap, bit 1 match A, bit 2 match B. A timer event at edge E sets its flag at system edge E+3 when src_sel is 0. Writing a 1 to a bit at address 6 clears that flag, with no busy check. When a set and a clear fall in the same cycle, the set wins.
- R10: A counter value transferred from staging replaces the count, and that cycle's tick is dropped. The reload raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, for the bus, busy bits and flags |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| osc_clk | input | 1 | Slow oscillator clock |
| src_sel | input | 1 | Timer clock source: 0 system, 1 oscillator |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| tcnt | output | 8 | Counter value, in the timer domain |
| pin_a | output | 1 | Compare output A |
| pin_b | output | 1 | Compare output B |

## Verification
A flag set pulse and a write-one clear of the same flag can land on the same system edge. The bench runs with the system clock as timer source at divide 1. It finds the wrap edge E by watching tcnt step from 255 to 0, then sweeps the clearing write over edges E+1 to E+5. The flag must read 1 for every offset up to 3, because the set pulse arrives at or after the clear, and 0 for offsets 4 and 5. A separate run with no clear confirms that the flag is still 0 after E+2 and is 1 after E+3.

// File: rtl/async_timer_bridge.sv
module async_timer_bridge #(
  parameter int W    = 8,
  parameter int NREG = 5,
  parameter int PSW  = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         osc_clk,
  input  logic         src_sel,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] tcnt,
  output logic         pin_a,
  output logic         pin_b
);
  localparam int NEV = 3;
  localparam logic [2:0] FLAG_ADDR = 3'd6;
  localparam logic [2:0] BUSY_ADDR = 3'd5;

  logic tclk;
  assign tclk = src_sel ? osc_clk : clk;

  logic [W-1:0]    stg [NREG];
  logic [NREG-1:0] req_t, ack_s1, ack_s2, busy;
  logic [NREG-1:0] req_s1, req_s2, ack_t, upd;
  logic [W-1:0]    cnt, cmp_a, cmp_b;
  logic [4:0]      ctl_a;
  logic [2:0]      ctl_b;
  logic [PSW-1:0]  presc;
  logic            tick, hit_a, hit_b, hit_max, wrap_a;
  logic [NEV-1:0]  ev_t, ev_s1, ev_s2, ev_s3, ev_set, flag, flag_clr;
  logic            pa, pb;

  assign busy     = req_t ^ ack_s2;
  assign upd      = req_s2 ^ ack_t;
  assign ev_set   = ev_s2 ^ ev_s3;
  assign flag_clr = (wr_en && wr_addr == FLAG_ADDR) ? wr_data[NEV-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) stg[k] <= '0;
      req_t  <= '0;
      ack_s1 <= '0;
      ack_s2 <= '0;
      ev_s1  <= '0;
      ev_s2  <= '0;
      ev_s3  <= '0;
      flag   <= '0;
    end else begin
      ack_s1 <= ack_t;
      ack_s2 <= ack_s1;
      ev_s1  <= ev_t;
      ev_s2  <= ev_s1;
      ev_s3  <= ev_s2;
      flag   <= (flag & ~flag_clr) | ev_set;
      for (int k = 0; k < NREG; k++) begin
        if (wr_en && wr_addr == 3'(k) && !busy[k]) begin
          stg[k]   <= wr_data;
          req_t[k] <= ~req_t[k];
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr < 3'(NREG))        rd_data = stg[rd_addr];
    else if (rd_addr == BUSY_ADDR) rd_data = W'(busy);
    else if (rd_addr == FLAG_ADDR) rd_data = W'(flag);
  end

  always_comb begin
    case (ctl_b)
      3'd0:    tick = 1'b0;
      3'd1:    tick = 1'b1;
      3'd2:    tick = &presc[2:0];
      3'd3:    tick = &presc[4:0];
      3'd4:    tick = &presc[5:0];
      3'd5:    tick = &presc[6:0];
      3'd6:    tick = &presc[7:0];
      default: tick = &presc[9:0];
    endcase
  end

  assign wrap_a  = ctl_a[4] && cnt == cmp_a;
  assign hit_a   = tick && !upd[0] && cnt == cmp_a;
  assign hit_b   = tick && !upd[0] && cnt == cmp_b;
  assign hit_max = tick && !upd[0] && cnt == {W{1'b1}};

  function automatic logic pin_next(input logic [1:0] mode, input logic cur);
    case (mode)
      2'b01:   return ~cur;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) begin
      req_s1 <= '0;
      req_s2 <= '0;
      ack_t  <= '0;
      presc  <= '0;
      cnt    <= '0;
      cmp_a  <= '0;
      cmp_b  <= '0;
      ctl_a  <= '0;
      ctl_b  <= '0;
      ev_t   <= '0;
      pa     <= 1'b0;
      pb     <= 1'b0;
    end else begin
      req_s1 <= req_t;
      req_s2 <= req_s1;
      ack_t  <= req_s2;
      presc  <= presc + PSW'(1);
      if (upd[0])    cnt <= stg[0];
      else if (tick) cnt <= wrap_a ? '0 : cnt + W'(1);
      if (upd[1]) cmp_a <= stg[1];
      if (upd[2]) cmp_b <= stg[2];
      if (upd[3]) ctl_a <= stg[3][4:0];
      if (upd[4]) ctl_b <= stg[4][2:0];
      ev_t <= ev_t ^ {hit_b, hit_a, hit_max};
      if (hit_a) pa <= pin_next(ctl_a[1:0], pa);
      if (hit_b) pb <= pin_next(ctl_a[3:2], pb);
    end
  end

  assign tcnt  = cnt;
  assign pin_a = pa;
  assign pin_b = pb;

  for (genvar g = 0; g < NREG; g++) begin : g_reg_chk
    p_busy_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 3'(g) && !busy[g]) |=> (busy[g] && stg[g] == $past(wr_data)));
    p_hold_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy[g] |=> $stable(stg[g]));
  end

  for (genvar j = 0; j < NEV; j++) begin : g_flag_chk
    p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ev_set[j] |=> flag[j]);
    p_flag_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[j] && !ev_set[j]) |=> !flag[j]);
  end

  p_ctc_zero_r7: assert property (@(posedge tclk) disable iff (!rst_n)
    (tick && !upd[0] && wrap_a) |=> cnt == '0);
  p_count_up_r6: assert property (@(posedge tclk) disable iff (!rst_n)
    (tick && !upd[0] && !wrap_a) |=> cnt == W'($past(cnt) + W'(1)));
  p_load_r10: assert property (@(posedge tclk) disable iff (!rst_n)
    upd[0] |=> cnt == $past(stg[0]));
  p_stopped_r5: assert property (@(posedge tclk) disable iff (!rst_n)
    (ctl_b == 3'd0 && !upd[0]) |=> $stable(cnt));
endmodule

// File: tb/sim_async_timer_bridge.sv
module sim_async_timer_bridge;
  logic       clk = 1'b0;
  logic       osc_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data, tcnt;
  logic       pin_a, pin_b;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  async_timer_bridge u0 (
    .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk), .src_sel(src_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tcnt(tcnt),
    .pin_a(pin_a), .pin_b(pin_b)
  );

  always #10 clk = ~clk;
  initial begin
    #3;
    forever #70 osc_clk = ~osc_clk;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_idle();
    logic [7:0] d;
    for (int i = 0; i < 400; i++) begin
      rd(3'd5, d);
      if (d[4:0] == 5'd0) break;
      @(negedge clk);
    end
  endtask

  task automatic measure_cnt(output int p);
    logic [7:0] a;
    int n;
    a = tcnt;
    n = 0;
    while (tcnt == a && n < 3000) begin @(negedge clk); n++; end
    a = tcnt;
    n = 0;
    do begin @(negedge clk); n++; end while (tcnt == a && n < 3000);
    p = n;
  endtask

  task automatic measure_pin(output int p);
    logic a;
    int n;
    a = pin_a;
    n = 0;
    while (pin_a == a && n < 3000) begin @(negedge clk); n++; end
    a = pin_a;
    n = 0;
    do begin @(negedge clk); n++; end while (pin_a == a && n < 3000);
    p = n;
  endtask

  task automatic pin_step(input logic [7:0] ca, input int ea, input int eb);
    logic [7:0] d;
    wr(3'd4, 8'd0);
    wr(3'd3, ca);
    wr(3'd0, 8'd3);
    wr(3'd1, 8'd5);
    wr(3'd2, 8'd5);
    wait_idle();
    wr(3'd6, 8'd7);
    wr(3'd4, 8'd1);
    repeat (12) @(negedge clk);
    wr(3'd4, 8'd0);
    wait_idle();
    chk("R8 pin_a after match", int'(pin_a), ea);
    chk("R8 pin_b after match", int'(pin_b), eb);
    rd(3'd6, d);
    chk("R9 both match flags", int'(d[2:1]), 3);
  endtask

  function automatic int div_of(input int code);
    case (code)
      1: return 1;
      2: return 8;
      3: return 32;
      4: return 64;
      5: return 128;
      6: return 256;
      default: return 1024;
    endcase
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d, prev;
    int p, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 counter", int'(tcnt), 0);
    chk("R1 pins", int'({pin_a, pin_b}), 0);
    rd(3'd5, d); chk("R1 busy", int'(d), 0);
    rd(3'd6, d); chk("R1 flags", int'(d), 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d); chk("R1 staged reg", int'(d), 0);
    end
    repeat (20) @(negedge clk);
    chk("R1 R5 stopped after reset", int'(tcnt), 0);

    wr(3'd2, 8'h55);
    for (int i = 0; i <= 5; i++) begin
      if (i > 0) @(negedge clk);
      rd(3'd5, d);
      chk("R3 busy window", int'(d[2]), (i < 5) ? 1 : 0);
    end
    rd(3'd2, d); chk("R3 staged readback", int'(d), 8'h55);

    wr(3'd1, 8'h10);
    wr(3'd1, 8'h20);
    rd(3'd1, d); chk("R4 write while busy ignored", int'(d), 8'h10);
    wait_idle();
    rd(3'd1, d); chk("R4 staged value kept", int'(d), 8'h10);

    wr(3'd0, 8'hF0);
    @(negedge clk); @(negedge clk);
    chk("R3 R10 not yet loaded at W+2", int'(tcnt), 0);
    @(negedge clk);
    chk("R3 R10 loaded at W+3", int'(tcnt), 8'hF0);
    wait_idle();

    for (int code = 1; code < 8; code++) begin
      wr(3'd4, 8'(code));
      wait_idle();
      measure_cnt(p);
      chk("R5 prescale period", p, div_of(code));
    end
    wr(3'd4, 8'd0);
    wait_idle();
    prev = tcnt;
    repeat (40) @(negedge clk);
    chk("R5 code 0 holds counter", int'(tcnt), int'(prev));

    wr(3'd3, 8'd0);
    wr(3'd4, 8'd1);
    wait_idle();
    for (int k = 0; k <= 5; k++) begin
      n = 0;
      while (tcnt != 8'hF0 && n < 600) begin @(negedge clk); n++; end
      wr(3'd6, 8'd1);
      n = 0;
      prev = tcnt;
      while (tcnt != 8'h00 && n < 600) begin prev = tcnt; @(negedge clk); n++; end
      if (k == 0) begin
        chk("R6 wrap from 255", int'(prev), 255);
        @(negedge clk); @(negedge clk);
        rd(3'd6, d); chk("R9 flag still clear at E+2", int'(d[0]), 0);
        @(negedge clk);
        rd(3'd6, d); chk("R9 flag set at E+3", int'(d[0]), 1);
      end else begin
        repeat (k - 1) @(negedge clk);
        wr(3'd6, 8'd1);
        repeat (6) @(negedge clk);
        rd(3'd6, d);
        chk("R9 set versus clear same cycle sweep", int'(d[0]), (k <= 3) ? 1 : 0);
      end
    end

    wr(3'd3, 8'h11);
    foreach (p_list[i]) begin
      wr(3'd1, p_list[i]);
      wait_idle();
      measure_pin(p);
      chk("R7 R8 CTC toggle period", p, int'(p_list[i]) + 1);
    end

    pin_step(8'h0F, 1, 1);
    pin_step(8'h06, 0, 0);
    pin_step(8'h00, 0, 0);
    pin_step(8'h07, 1, 1);
    pin_step(8'h00, 1, 1);

    wr(3'd4, 8'd0);
    wait_idle();
    repeat (4) @(negedge clk);
    src_sel = 1'b1;
    repeat (4) @(negedge clk);
    wr(3'd3, 8'd0);
    wr(3'd0, 8'd0);
    wait_idle();
    wr(3'd2, 8'h40);
    n = 0;
    do begin rd(3'd5, d); if (d[2]) begin @(negedge clk); n++; end end while (d[2] && n < 400);
    chk("R2 R3 async busy lasts longer than sync", int'(n >= 8 && n <= 40), 1);
    wr(3'd0, 8'h80);
    wait_idle();
    chk("R2 R10 async counter load", int'(tcnt), 8'h80);
    wr(3'd4, 8'd1);
    wait_idle();
    measure_cnt(p);
    chk("R2 count follows oscillator", p, 7);
    wr(3'd6, 8'd7);
    n = 0;
    do begin @(negedge clk); rd(3'd6, d); n++; end while (!d[0] && n < 3000);
    chk("R2 R9 async wrap flag", int'(d[0]), 1);

    done = 1;
    summary();
    $finish;
  end

  logic [7:0] p_list [7] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd7, 8'd31, 8'd200};
endmodule